// File: doc/BRIEF.md
# Indirect Video-Memory Access Port

This block gives a host processor access to a word-organised video memory that is outside the processor's own address space. The host works through three 16-bit registers on a small host bus. One register holds the memory address. One is a data port. The third holds a signed modifier that is added to the address after every data-port write. The memory has two zones: a slow lower zone and a fast upper zone. A video renderer owns most access cycles in both zones on a fixed schedule, and host traffic may only use the slots the renderer leaves free.

When the host writes the address register, a prefetch read is queued and completes in the next free slot of the target zone; the data port then returns the latched word. A data-port write is posted into a one-entry buffer and drains in the next free slot of its zone. The `busy` output stays high while either operation is outstanding. The auto-modify adder never changes the zone bit, so software must reload the address register to move between zones.

Top module: `vmem_port`

## Requirements
- R1: Registers are selected by byte offset on `host_addr`: 0 is the address, 2 is the data port, 4 is the modifier. Offset 6 and any odd offset select nothing: a write there has no effect and a read there returns 0. Reads of offsets 0 and 4 return the stored register value.
- R2: A data-port write whose address has bit 15 clear stores the word at that address. It then sets the address to (address + modifier) mod 2^15, with bit 15 kept at 0.
- R3: A data-port write whose address has bit 15 set keeps address bits 15..11 and replaces bits 10..0 with (address + modifier) mod 2^11.
- R4: Auto-modify never crosses zones. $7FFF plus 1 gives $0000, $0000 minus 1 gives $7FFF, $87FF plus 1 gives $8000, and $8000 minus 1 gives $87FF.
- R5: After an address write, once `busy` is low, offset 2 reads the memory word at the written address.
- R6: `busy` is high in the cycle after a write to offset 0 or 2. It returns low within 2·LO_PERIOD·LO_FRAME clocks, which is 24 with the defaults.
- R7: The host gets one lower-zone slot every LO_PERIOD·LO_FRAME clocks (12 with the defaults) and one upper-zone slot every HI_FRAME clocks (4 with the defaults). A single operation therefore completes within that many clocks.
- R8: Each zone's storage is indexed by the low LO_MEM_AW bits of the address in the lower zone and the low HI_MEM_AW bits in the upper zone, so higher addresses alias onto these words.
- R9: After reset, the address, data and modifier registers read 0 and `busy` is low.
- R10: A pending posted write is performed before a prefetch to the same zone in the same slot, so a prefetch of the address just written returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host byte offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Register read data (combinational on `host_addr`) |
| busy | output | 1 | A posted write or prefetch is outstanding |

## Verification
Register effects are visible at the first clock edge after the write strobe. Address arithmetic is therefore read back at the next falling edge, which proves R1 to R4 with no wait. Memory results depend on the slot schedule: they are due k clocks after the write, where k is at most 12 for the lower zone, 4 for the upper zone, and 24 for a write followed by a prefetch in the same zone. The bench counts falling edges while `busy` is high, checks that count against the bound, and only then samples the data port.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
    localparam int VP_DW    = 16;
    localparam int ZONE_BIT = 15;
    localparam int LO_WRAP  = 15;
    localparam int HI_WRAP  = 11;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_MOD  = 2'd2,
        SEL_NONE = 2'd3
    } vp_sel_e;

    typedef struct packed {
        logic [VP_DW-1:0] addr;
        logic [VP_DW-1:0] modv;
        logic [VP_DW-1:0] rdat;
        logic [VP_DW-1:0] pf_addr;
        logic [VP_DW-1:0] wb_addr;
        logic [VP_DW-1:0] wb_data;
        logic             wb_pend;
        logic             pf_pend;
    } vp_state_t;

    // zone-preserving post-write address update
    function automatic logic [VP_DW-1:0] vp_bump(input logic [VP_DW-1:0] a,
                                                 input logic [VP_DW-1:0] m);
        logic [VP_DW-1:0] sum;
        logic [VP_DW-1:0] lo_mask;
        logic [VP_DW-1:0] hi_mask;
        sum     = a + m;
        lo_mask = VP_DW'((1 << LO_WRAP) - 1);
        hi_mask = VP_DW'((1 << HI_WRAP) - 1);
        if (a[ZONE_BIT]) return (a & ~hi_mask) | (sum & hi_mask);
        else             return sum & lo_mask;
    endfunction
endpackage

// File: rtl/vmem_slot_gen.sv
module vmem_slot_gen #(
    parameter int PERIOD = 3,
    parameter int FRAME  = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic cpu_slot
);
    localparam int TOTAL = PERIOD * FRAME;
    localparam int CW    = $clog2(TOTAL);

    logic [CW-1:0] cnt_d, cnt_q;

    // renderer owns every access except the last one of each round
    always_comb begin
        cpu_slot = (cnt_q == CW'(TOTAL - 1));
        cnt_d    = cpu_slot ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/vmem_zone_ram.sv
module vmem_zone_ram #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [2**AW];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/vmem_port.sv
module vmem_port
    import vmem_pkg::*;
#(
    parameter int LO_PERIOD = 3,
    parameter int LO_FRAME  = 4,
    parameter int HI_FRAME  = 4,
    parameter int LO_MEM_AW = 10,
    parameter int HI_MEM_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [2:0]       host_addr,
    input  logic [VP_DW-1:0] host_wdata,
    output logic [VP_DW-1:0] host_rdata,
    output logic             busy
);
    vp_state_t st_d, st_q;

    logic [1:0]       slot;
    logic [1:0]       zwe;
    logic [VP_DW-1:0] zaddr  [2];
    logic [VP_DW-1:0] zrdata [2];
    vp_sel_e          sel;
    logic             go_wr, go_pf;

    for (genvar z = 0; z < 2; z++) begin : g_zone
        localparam int P   = (z == 0) ? LO_PERIOD : 1;
        localparam int F   = (z == 0) ? LO_FRAME  : HI_FRAME;
        localparam int AWZ = (z == 0) ? LO_MEM_AW : HI_MEM_AW;

        vmem_slot_gen #(.PERIOD(P), .FRAME(F)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cpu_slot (slot[z])
        );

        vmem_zone_ram #(.DW(VP_DW), .AW(AWZ)) u_ram (
            .clk   (clk),
            .we    (zwe[z]),
            .addr  (zaddr[z][AWZ-1:0]),
            .wdata (st_q.wb_data),
            .rdata (zrdata[z])
        );
    end

    always_comb begin
        sel = host_addr[0] ? SEL_NONE : vp_sel_e'(host_addr[2:1]);

        // posted write wins the slot over a prefetch in the same zone
        go_wr = st_q.wb_pend && slot[st_q.wb_addr[ZONE_BIT]];
        go_pf = st_q.pf_pend && slot[st_q.pf_addr[ZONE_BIT]] &&
                !(go_wr && (st_q.wb_addr[ZONE_BIT] == st_q.pf_addr[ZONE_BIT]));

        for (int z = 0; z < 2; z++) begin
            zwe[z]   = go_wr && (st_q.wb_addr[ZONE_BIT] == z[0]);
            zaddr[z] = zwe[z] ? st_q.wb_addr : st_q.pf_addr;
        end

        st_d = st_q;
        if (go_wr) st_d.wb_pend = 1'b0;
        if (go_pf) begin
            st_d.pf_pend = 1'b0;
            st_d.rdat    = zrdata[st_q.pf_addr[ZONE_BIT]];
        end

        if (host_we) begin
            case (sel)
                SEL_ADDR: begin
                    st_d.addr    = host_wdata;
                    st_d.pf_addr = host_wdata;
                    st_d.pf_pend = 1'b1;
                end
                SEL_DATA: begin
                    st_d.wb_addr = st_q.addr;
                    st_d.wb_data = host_wdata;
                    st_d.wb_pend = 1'b1;
                    st_d.addr    = vp_bump(st_q.addr, st_q.modv);
                end
                SEL_MOD:  st_d.modv = host_wdata;
                default:  ;
            endcase
        end

        case (sel)
            SEL_ADDR: host_rdata = st_q.addr;
            SEL_DATA: host_rdata = st_q.rdat;
            SEL_MOD:  host_rdata = st_q.modv;
            default:  host_rdata = '0;
        endcase

        busy = st_q.wb_pend || st_q.pf_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vmem_port_chk.sv
module vmem_port_chk #(
    parameter int MAX_WAIT = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic [2:0]  host_addr,
    input logic [15:0] host_wdata,
    input logic        busy,
    input logic [15:0] addr,
    input logic [15:0] modv
);
    logic       wr_addr, wr_data;
    logic [7:0] wcnt;

    assign wr_addr = host_we && (host_addr == 3'd0);
    assign wr_data = host_we && (host_addr == 3'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   wcnt <= '0;
        else if (wr_addr || wr_data)  wcnt <= '0;
        else if (!busy)               wcnt <= '0;
        else if (wcnt != 8'hFF)       wcnt <= wcnt + 1'b1;
    end

    a_r1_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr |=> addr == $past(host_wdata));

    a_r2_lo_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !addr[15]) |=>
            (addr[14:0] == 15'($past(addr[14:0]) + $past(modv[14:0]))));

    a_r3_hi_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && addr[15]) |=> addr[15:11] == $past(addr[15:11]));

    a_r4_zone_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> addr[15] == $past(addr[15]));

    a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr || wr_data) |=> busy);

    a_r6_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= 8'(MAX_WAIT));
endmodule

bind vmem_port vmem_port_chk #(.MAX_WAIT(2 * LO_PERIOD * LO_FRAME)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .addr       (st_q.addr),
    .modv       (st_q.modv)
);

// File: tb/vmem_port_bench.sv
module vmem_port_bench;
    localparam int LO_AW = 4;
    localparam int HI_AW = 3;
    localparam int LO_WIN = 12;
    localparam int HI_WIN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        busy;

    int errors = 0;
    int checks = 0;

    logic [15:0] lo_m [2**LO_AW];
    logic [15:0] hi_m [2**HI_AW];

    logic [15:0] lo_addrs [4] = '{16'h0000, 16'h7FFF, 16'h1234, 16'h7FF0};
    logic [15:0] hi_addrs [4] = '{16'h8000, 16'h87FF, 16'h8123, 16'h8700};
    logic [15:0] mods     [5] = '{16'h0001, 16'hFFFF, 16'h0010, 16'h7FFF, 16'h8000};

    always #2.5 clk = ~clk;

    vmem_port #(.LO_PERIOD(3), .LO_FRAME(4), .HI_FRAME(4),
                .LO_MEM_AW(LO_AW), .HI_MEM_AW(HI_AW)) u_vmem_port (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] o, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = o; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] o, output logic [15:0] v);
        host_addr = o;
        #1;
        v = host_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [15:0] exp_bump(input logic [15:0] a, input logic [15:0] m);
        logic [15:0] s;
        s = a + m;
        if (a[15]) return (a & 16'hF800) | (s & 16'h07FF);
        return s & 16'h7FFF;
    endfunction

    task automatic data_write(input logic [15:0] d, input int win, input string req);
        logic [15:0] a;
        int n;
        rd(3'd0, a);
        wr(3'd2, d);
        if (a[15]) hi_m[a[HI_AW-1:0]] = d;
        else       lo_m[a[LO_AW-1:0]] = d;
        wait_idle(n);
        check(req, 16'(n <= win), 16'd1);
    endtask

    task automatic read_back(input logic [15:0] a, input string req);
        logic [15:0] v;
        int n;
        wr(3'd0, a);
        wait_idle(n);
        check("R7 prefetch slot wait", 16'(n <= (a[15] ? HI_WIN : LO_WIN)), 16'd1);
        rd(3'd2, v);
        check(req, v, a[15] ? hi_m[a[HI_AW-1:0]] : lo_m[a[LO_AW-1:0]]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R6 act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd(3'd0, v); check("R9 addr", v, 16'h0000);
        rd(3'd2, v); check("R9 data", v, 16'h0000);
        rd(3'd4, v); check("R9 mod",  v, 16'h0000);
        check("R9 busy", 16'(busy), 16'd0);

        // R1 register selection and unused offsets
        wr(3'd4, 16'h1234);
        rd(3'd4, v); check("R1 mod readback", v, 16'h1234);
        wr(3'd6, 16'hBEEF);
        rd(3'd6, v); check("R1 offset 6 reads 0", v, 16'h0000);
        wr(3'd5, 16'hBEEF);
        rd(3'd4, v); check("R1 odd offset ignored", v, 16'h1234);
        rd(3'd0, v); check("R1 addr untouched", v, 16'h0000);
        check("R1 no busy", 16'(busy), 16'd0);

        // R2 / R3 / R4 modifier sweeps in both zones
        d = 16'h1000;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 5; j++) begin
                wr(3'd0, lo_addrs[i]); wait_idle(n);
                wr(3'd4, mods[j]);
                data_write(d, LO_WIN, "R7 lower write slot");
                rd(3'd0, v); check("R2 lower bump", v, exp_bump(lo_addrs[i], mods[j]));
                d++;
                wr(3'd0, hi_addrs[i]); wait_idle(n);
                data_write(d, HI_WIN, "R7 upper write slot");
                rd(3'd0, v); check("R3 upper bump", v, exp_bump(hi_addrs[i], mods[j]));
                d++;
            end
        end

        // R4 explicit boundary cases
        wr(3'd4, 16'h0001);
        wr(3'd0, 16'h7FFF); wait_idle(n); data_write(16'hA001, LO_WIN, "R7 lower");
        rd(3'd0, v); check("R4 7FFF+1", v, 16'h0000);
        wr(3'd0, 16'h87FF); wait_idle(n); data_write(16'hA002, HI_WIN, "R7 upper");
        rd(3'd0, v); check("R4 87FF+1", v, 16'h8000);
        wr(3'd4, 16'hFFFF);
        wr(3'd0, 16'h0000); wait_idle(n); data_write(16'hA003, LO_WIN, "R7 lower");
        rd(3'd0, v); check("R4 0000-1", v, 16'h7FFF);
        wr(3'd0, 16'h8000); wait_idle(n); data_write(16'hA004, HI_WIN, "R7 upper");
        rd(3'd0, v); check("R4 8000-1", v, 16'h87FF);

        // R8 fill with auto-increment, aliasing twice
        wr(3'd4, 16'h0001);
        wr(3'd0, 16'h0000); wait_idle(n);
        for (int i = 0; i < 2 * (2**LO_AW); i++) data_write(16'h5A00 + 16'(i), LO_WIN, "R7 lower fill");
        wr(3'd0, 16'h8000); wait_idle(n);
        for (int i = 0; i < 2 * (2**HI_AW); i++) data_write(16'hC300 + 16'(i), HI_WIN, "R7 upper fill");

        // R5 / R8 read-back sweeps
        for (int i = 0; i < 2 * (2**LO_AW); i++) read_back(16'(i), "R5 R8 lower read");
        for (int i = 0; i < 2 * (2**HI_AW); i++) read_back(16'h8000 + 16'(i), "R5 R8 upper read");
        read_back(16'h7FF3, "R8 lower alias high");
        read_back(16'h87FE, "R8 upper alias high");

        // R10 write then prefetch of the same address
        for (int z = 0; z < 2; z++) begin
            logic [15:0] a;
            a = (z == 0) ? 16'h0005 : 16'h8006;
            wr(3'd4, 16'h0000);
            wr(3'd0, a); wait_idle(n);
            wr(3'd2, 16'hD000 + 16'(z));
            if (a[15]) hi_m[a[HI_AW-1:0]] = 16'hD000 + 16'(z);
            else       lo_m[a[LO_AW-1:0]] = 16'hD000 + 16'(z);
            wr(3'd0, a);
            wait_idle(n);
            check("R6 combined wait", 16'(n <= 2 * LO_WIN), 16'd1);
            rd(3'd2, v);
            check("R10 write before prefetch", v, 16'hD000 + 16'(z));
        end

        // R6 busy raised after an address write
        wr(3'd0, 16'h0001);
        check("R6 busy after write", 16'(busy), 16'd1);
        wait_idle(n);
        check("R6 busy clears", 16'(busy), 16'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule